// File: doc/BRIEF.md
# Four-Error ECC Correction Sequencer

This block runs the correction phase for one 512-byte data chunk protected by a four-error syndrome engine. A caller pulses `go` with the ten ECC bytes that were stored alongside the chunk. The sequencer first decides whether the chunk is erased. If it is not, it feeds the stored code into the engine, checks the syndrome, and starts the engine's error-location step. It then waits out a window in which the engine's status misreports completion, decodes the final state, and fetches up to four error locations with their values. Each in-range fix is applied to the chunk buffer by a single-cycle read-modify-write.

The engine itself is outside the block. It appears only as a load port, a start pulse, a status word, a 128-bit syndrome, and two address/value register pairs. The chunk buffer is reached through a byte-wide port with a combinational read path. The outcome is a one-cycle `done` pulse together with `fail` and the number of bytes repaired.

Top module: `ecc4fix_seq`

## Requirements
- R1: If all 80 bits of `stored_ecc` are 1 when `go` is taken, the next cycle shows `done` with `fail`=0 and `fixed_cnt`=0. No load, no start pulse and no buffer write occur.
- R2: Stored byte k occupies `stored_ecc[8k+7:8k]`. Code value j (0..7) is bits 10j+9..10j of that little-endian 80-bit stream.
- R3: A non-erased run issues exactly eight `eng_load_valid` cycles back to back. They carry code values 7, 6, … 0 in that order, and no load ever coincides with a start pulse or a buffer write.
- R4: If all 128 bits of `syndrome` are 0 after loading, the run ends with `fail`=0 and `fixed_cnt`=0, and no `eng_calc_start` is issued.
- R5: After `eng_calc_start`, a state value below 4 is not acted on until either a state of 4 or more has been observed or `GUARD_CYCLES` cycles have elapsed.
- R6: The state field is `eng_status[11:8]`. After the guard window, 0 ends the run with no fix, 1 ends it with `fail`=1 and `fixed_cnt`=0, 2 or 3 starts correction, and 4 or more keeps polling.
- R7: The number of errors to process is 1 plus `eng_status[17:16]`. The value is taken when state 2 or 3 is decoded.
- R8: Errors 0 and 1 use `pair_a_addr`/`pair_a_val`, and errors 2 and 3 use `pair_b_addr`/`pair_b_val`. An even-numbered error reads address bits 9:0 and value bits 7:0; an odd-numbered error reads address bits 25:16 and value bits 23:16.
- R9: A raw address r maps to byte offset 519−r. The byte is replaced by itself XOR the value only when 8 ≤ r ≤ 519. `fixed_cnt` counts only applied fixes, and other buffer bytes stay unchanged.
- R10: `done` is high for exactly one cycle per run. `busy` is high from the cycle after `go` until the run ends, and `go` is ignored while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start one correction run |
| stored_ecc | input | 80 | Ten stored ECC bytes, byte k at bits 8k+7:8k |
| syndrome | input | 128 | Engine syndrome words after loading |
| eng_status | input | 32 | Engine status: state in 11:8, error count in 17:16 |
| pair_a_addr | input | 32 | Error addresses 0 (9:0) and 1 (25:16) |
| pair_b_addr | input | 32 | Error addresses 2 (9:0) and 3 (25:16) |
| pair_a_val | input | 32 | Error values 0 (7:0) and 1 (23:16) |
| pair_b_val | input | 32 | Error values 2 (7:0) and 3 (23:16) |
| eng_load_valid | output | 1 | Expected-code load strobe |
| eng_load_data | output | 10 | Expected-code value being loaded |
| eng_calc_start | output | 1 | One-cycle start of the error-location step |
| buf_addr | output | 9 | Chunk buffer byte address |
| buf_rdata | input | 8 | Chunk buffer read data (combinational) |
| buf_wr_en | output | 1 | Chunk buffer write enable |
| buf_wdata | output | 8 | Chunk buffer write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one-cycle pulse) |
| fail | output | 1 | Uncorrectable chunk (five or more errors) |
| fixed_cnt | output | 3 | Number of bytes repaired |

## Verification
The stimulus set contains several kinds of chunk. An erased chunk separates the early exit from a full run. A clean-syndrome chunk separates the short path from one that starts the location step. Runs ending in state 0, 1, 2 and 3 separate the four outcomes of the final decode.

Each correction pattern places addresses in a different half and register pair. Some raw addresses sit at both ends of the valid range and some fall outside it, so a wrong register choice, a wrong half or a wrong bound each leaves a different byte image and count.

The engine stub shows a false "complete" with a different count before going busy, which exposes any decode taken too early. One run never shows a busy state, which confirms that the timeout releases the guard. The load order is compared with the code values recomputed bit by bit from the stored bytes.

// File: rtl/ecc4fix_pkg.sv
package ecc4fix_pkg;
    localparam int unsigned CODE_W    = 10;
    localparam int unsigned CODE_N    = 8;
    localparam int unsigned BYTE_N    = 10;
    localparam int unsigned ECC_W     = BYTE_N * 8;
    localparam int unsigned CHUNK     = 512;
    localparam int unsigned OFF_W     = $clog2(CHUNK);
    localparam int unsigned ADDR_BIAS = CHUNK + 7;
    localparam int unsigned SYN_W     = 128;
    localparam int unsigned CNT_W     = 3;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_SYN, S_START, S_POLL, S_FIX
    } seq_state_e;

    typedef struct packed {
        logic             apply;
        logic [OFF_W-1:0] offset;
        logic [7:0]       val;
    } fix_t;

    function automatic logic [CODE_W-1:0] code_at(input logic [ECC_W-1:0] b,
                                                  input logic [2:0] j);
        return b[j*CODE_W +: CODE_W];
    endfunction

    function automatic fix_t xlate(input logic [CODE_W-1:0] raw, input logic [7:0] v);
        fix_t f;
        logic [CODE_W:0] diff;
        diff     = (CODE_W+1)'(ADDR_BIAS) - {1'b0, raw};
        f.apply  = ({1'b0, raw} >= (CODE_W+1)'(ADDR_BIAS - CHUNK + 1))
                && ({1'b0, raw} <= (CODE_W+1)'(ADDR_BIAS));
        f.offset = diff[OFF_W-1:0];
        f.val    = v;
        return f;
    endfunction
endpackage

// File: rtl/ecc4fix_guard.sv
module ecc4fix_guard #(
    parameter int unsigned GUARD_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic [3:0] state,
    output logic       settled
);
    localparam int unsigned TW = $clog2(GUARD_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(GUARD_CYCLES - 1);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt    <= '0;
            settled <= 1'b0;
        end else if (arm) begin
            tcnt    <= '0;
            settled <= 1'b0;
        end else if (!settled) begin
            if (state >= 4'd4 || tcnt == LAST) settled <= 1'b1;
            tcnt <= tcnt + 1'b1;
        end
    end

    // R5
    rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> !settled);
endmodule

// File: rtl/ecc4fix_pick.sv
module ecc4fix_pick
    import ecc4fix_pkg::*;
(
    input  logic [1:0]  eidx,
    input  logic [31:0] a_addr,
    input  logic [31:0] b_addr,
    input  logic [31:0] a_val,
    input  logic [31:0] b_val,
    output fix_t        fix
);
    logic [31:0] areg, vreg;
    logic [CODE_W-1:0] raw;
    logic [7:0] v;

    always_comb begin
        areg = eidx[1] ? b_addr : a_addr;
        vreg = eidx[1] ? b_val  : a_val;
        raw  = eidx[0] ? areg[16 +: CODE_W] : areg[0 +: CODE_W];
        v    = eidx[0] ? vreg[23:16] : vreg[7:0];
        fix  = xlate(raw, v);
    end
endmodule

// File: rtl/ecc4fix_seq.sv
module ecc4fix_seq
    import ecc4fix_pkg::*;
#(
    parameter int unsigned GUARD_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ECC_W-1:0]  stored_ecc,
    input  logic [SYN_W-1:0]  syndrome,
    input  logic [31:0]       eng_status,
    input  logic [31:0]       pair_a_addr,
    input  logic [31:0]       pair_b_addr,
    input  logic [31:0]       pair_a_val,
    input  logic [31:0]       pair_b_val,
    output logic              eng_load_valid,
    output logic [CODE_W-1:0] eng_load_data,
    output logic              eng_calc_start,
    output logic [OFF_W-1:0]  buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  fixed_cnt
);
    seq_state_e       st;
    logic [2:0]       cidx;
    logic [1:0]       eidx;
    logic [1:0]       elast;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] acc_n;
    logic             settled;
    logic [3:0]       eng_state;
    fix_t             fix;

    assign eng_state = eng_status[11:8];

    ecc4fix_guard #(.GUARD_CYCLES(GUARD_CYCLES)) guard_i (
        .clk(clk), .rst(rst), .arm(eng_calc_start),
        .state(eng_state), .settled(settled)
    );

    ecc4fix_pick pick_i (
        .eidx(eidx), .a_addr(pair_a_addr), .b_addr(pair_b_addr),
        .a_val(pair_a_val), .b_val(pair_b_val), .fix(fix)
    );

    always_comb begin
        eng_load_valid = (st == S_LOAD);
        eng_load_data  = code_at(stored_ecc, cidx);
        eng_calc_start = (st == S_START);
        buf_addr       = fix.offset;
        buf_wr_en      = (st == S_FIX) && fix.apply;
        buf_wdata      = buf_rdata ^ fix.val;
        busy           = (st != S_IDLE);
        acc_n          = acc + CNT_W'(fix.apply);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            cidx      <= 3'(CODE_N - 1);
            eidx      <= '0;
            elast     <= '0;
            acc       <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            fixed_cnt <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                S_IDLE: if (go) begin
                    acc <= '0;
                    if (&stored_ecc) begin
                        done      <= 1'b1;
                        fail      <= 1'b0;
                        fixed_cnt <= '0;
                    end else begin
                        cidx <= 3'(CODE_N - 1);
                        st   <= S_LOAD;
                    end
                end
                S_LOAD: begin
                    if (cidx == 3'd0) st <= S_SYN;
                    else cidx <= cidx - 1'b1;
                end
                S_SYN: begin
                    if (syndrome == '0) begin
                        done      <= 1'b1;
                        fail      <= 1'b0;
                        fixed_cnt <= '0;
                        st        <= S_IDLE;
                    end else begin
                        st <= S_START;
                    end
                end
                S_START: st <= S_POLL;
                S_POLL: if (settled && eng_state < 4'd4) begin
                    if (eng_state <= 4'd1) begin
                        done      <= 1'b1;
                        fail      <= eng_state[0];
                        fixed_cnt <= '0;
                        st        <= S_IDLE;
                    end else begin
                        elast <= eng_status[17:16];
                        eidx  <= '0;
                        st    <= S_FIX;
                    end
                end
                S_FIX: begin
                    if (eidx == elast) begin
                        done      <= 1'b1;
                        fail      <= 1'b0;
                        fixed_cnt <= acc_n;
                        st        <= S_IDLE;
                    end else begin
                        eidx <= eidx + 1'b1;
                        acc  <= acc_n;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R1
    erased_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && go && (&stored_ecc)) |=> (done && !fail && fixed_cnt == '0));
    // R6
    fail_nofix_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (fixed_cnt == '0));
    // R3
    load_excl_chk: assert property (@(posedge clk) disable iff (rst)
        eng_load_valid |-> (busy && !eng_calc_start && !buf_wr_en));
    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (fixed_cnt <= CNT_W'(4)));
endmodule

// File: tb/ecc4fix_seq_tb.sv
module ecc4fix_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GUARD      = 12;
    localparam int NVEC       = 8;

    typedef struct packed {
        logic [79:0] ecc;
        logic        syn_zero;
        logic [7:0]  quirk;
        logic [7:0]  busyc;
        logic [3:0]  fin;
        logic [1:0]  cnt;
        logic [31:0] aa;
        logic [31:0] ab;
        logic [31:0] va;
        logic [31:0] vb;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{ {80{1'b1}}, 1'b0, 8'd2, 8'd3, 4'd2, 2'd3, 32'h0001_0002, 32'h0, 32'h11, 32'h0 },
        '{ 80'h0123_4567_89AB_CDEF_1357, 1'b1, 8'd2, 8'd3, 4'd2, 2'd0, 32'h0000_0100, 32'h0, 32'h11, 32'h0 },
        '{ 80'hA5C3_0F1E_2D3C_4B5A_6978, 1'b0, 8'd3, 8'd4, 4'd2, 2'd3, 32'h01A3_01FD, 32'h0207_0008, 32'h0001_005A, 32'h00FF_0080 },
        '{ 80'h1111_2222_3333_4444_5555, 1'b0, 8'd2, 8'd3, 4'd3, 2'd1, 32'h012C_0005, 32'h0, 32'h0044_0077, 32'h0 },
        '{ 80'hFFFF_FFFF_FFFF_FFFF_FFFE, 1'b0, 8'd2, 8'd3, 4'd1, 2'd2, 32'h0100_0100, 32'h0100_0100, 32'h00FF_00FF, 32'h00FF_00FF },
        '{ 80'h0000_0000_0000_0000_0001, 1'b0, 8'd2, 8'd3, 4'd0, 2'd2, 32'h0100_0100, 32'h0, 32'h00FF_00FF, 32'h0 },
        '{ 80'h8001_7FFE_4002_3FFD_2004, 1'b0, 8'd0, 8'd0, 4'd2, 2'd0, 32'h0000_0200, 32'h0, 32'h0000_0033, 32'h0 },
        '{ 80'hDEAD_BEEF_CAFE_F00D_1234, 1'b0, 8'd2, 8'd3, 4'd2, 2'd2, 32'h00C8_0258, 32'h012C_0009, 32'h0011_0022, 32'h0066_0055 }
    };

    logic clk = 1'b0, rst = 1'b1, go = 1'b0;
    logic [79:0]  stored_ecc = '0;
    logic [127:0] syndrome;
    logic [31:0]  eng_status, pair_a_addr = '0, pair_b_addr = '0, pair_a_val = '0, pair_b_val = '0;
    logic         eng_load_valid, eng_calc_start, buf_wr_en, busy, done, fail;
    logic [9:0]   eng_load_data;
    logic [8:0]   buf_addr;
    logic [7:0]   buf_rdata, buf_wdata;
    logic [2:0]   fixed_cnt;

    int checks = 0, errors = 0;
    logic init_req = 1'b0;
    logic syn_zero_v = 1'b0;
    logic [7:0] quirk_v = '0, busy_v = '0;
    logic [3:0] fin_v = '0;
    logic [1:0] cnt_v = '0;

    logic [7:0] mem [512];
    logic [9:0] ldrec [8];
    int nload, nstart, scnt, cyc, start_cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc4fix_seq #(.GUARD_CYCLES(GUARD)) dut_i (
        .clk(clk), .rst(rst), .go(go), .stored_ecc(stored_ecc), .syndrome(syndrome),
        .eng_status(eng_status), .pair_a_addr(pair_a_addr), .pair_b_addr(pair_b_addr),
        .pair_a_val(pair_a_val), .pair_b_val(pair_b_val),
        .eng_load_valid(eng_load_valid), .eng_load_data(eng_load_data),
        .eng_calc_start(eng_calc_start), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata), .busy(busy), .done(done),
        .fail(fail), .fixed_cnt(fixed_cnt)
    );

    // engine stub: false "complete" phase, busy phase, then final state
    always_comb begin
        logic [3:0] s;
        logic [1:0] c;
        c = 2'd0;
        if (scnt < int'(quirk_v)) s = 4'd3;
        else if (scnt < int'(quirk_v) + int'(busy_v)) s = 4'd9;
        else begin s = fin_v; c = cnt_v; end
        eng_status = {14'b0, c, 4'b0, s, 8'h01};
        syndrome   = syn_zero_v ? 128'h0 : 128'h1;
        buf_rdata  = mem[buf_addr];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (init_req) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 37 + 5);
            nload <= 0; nstart <= 0; scnt <= 1000;
        end else begin
            if (buf_wr_en) mem[buf_addr] <= buf_wdata;
            if (eng_load_valid) begin
                if (nload < 8) ldrec[nload] <= eng_load_data;
                nload <= nload + 1;
            end
            if (eng_calc_start) begin
                nstart <= nstart + 1; scnt <= 0; start_cyc <= cyc;
            end else if (scnt < 1000) scnt <= scnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] ref_code(input logic [79:0] e, input int j);
        logic [9:0] r;
        for (int b = 0; b < 10; b++) begin
            int p;
            p = 10 * j + b;
            r[b] = e[(p / 8) * 8 + (p % 8)];
        end
        return r;
    endfunction

    task automatic run_vec(input int n);
        vec_t v;
        logic [7:0] exp_mem [512];
        int exp_cnt, exp_loads, exp_starts, waited, done_cyc;
        bit exp_fail, erased, fixing;
        v = VEC[n];
        @(negedge clk);
        init_req = 1'b1;
        stored_ecc = v.ecc; syn_zero_v = v.syn_zero; quirk_v = v.quirk; busy_v = v.busyc;
        fin_v = v.fin; cnt_v = v.cnt;
        pair_a_addr = v.aa; pair_b_addr = v.ab; pair_a_val = v.va; pair_b_val = v.vb;
        @(negedge clk);
        init_req = 1'b0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        done_cyc = cyc;
        if (!done) check(1'b0, "R10 watchdog", 0, 1);

        // expected outcome computed from the requirements
        for (int i = 0; i < 512; i++) exp_mem[i] = 8'(i * 37 + 5);
        erased = &v.ecc;
        exp_loads  = erased ? 0 : 8;
        exp_starts = (erased || v.syn_zero) ? 0 : 1;
        exp_fail   = !erased && !v.syn_zero && v.fin == 4'd1;
        fixing     = !erased && !v.syn_zero && (v.fin == 4'd2 || v.fin == 4'd3);
        exp_cnt = 0;
        if (fixing) begin
            for (int e = 0; e <= int'(v.cnt); e++) begin
                logic [31:0] ar, vr;
                int raw;
                logic [7:0] ev;
                ar  = (e < 2) ? v.aa : v.ab;
                vr  = (e < 2) ? v.va : v.vb;
                raw = (e % 2 == 1) ? int'(ar[25:16]) : int'(ar[9:0]);
                ev  = (e % 2 == 1) ? vr[23:16] : vr[7:0];
                if (raw >= 8 && raw <= 519) begin
                    exp_mem[519 - raw] = exp_mem[519 - raw] ^ ev;
                    exp_cnt++;
                end
            end
        end

        check(fail == exp_fail, "R6 fail flag", int'(fail), int'(exp_fail));
        check(int'(fixed_cnt) == exp_cnt, "R9 fixed count", int'(fixed_cnt), exp_cnt);
        check(nload == exp_loads, "R3 load count", nload, exp_loads);
        check(nstart == exp_starts, "R4 start count", nstart, exp_starts);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
            check(bad == 0, "R8 buffer image", bad, 0);
        end
        if (exp_loads == 8) begin
            int bad;
            bad = 0;
            for (int k = 0; k < 8; k++) if (ldrec[k] !== ref_code(v.ecc, 7 - k)) bad++;
            check(bad == 0, "R2 load values order", bad, 0);
        end
        if (n == 6) check(done_cyc - start_cyc >= GUARD, "R5 guard timeout", done_cyc - start_cyc, GUARD);
        if (n == 2) check(fixed_cnt == 3'd4, "R7 four errors", int'(fixed_cnt), 4);
        @(negedge clk);
        check(!done && !busy, "R10 single done pulse", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        init_req = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        init_req = 1'b0;
        check(!busy && !done, "R10 reset idle", int'(busy), 0);
        check(!eng_load_valid && !eng_calc_start, "R3 reset no load", int'(eng_load_valid), 0);
        check(!buf_wr_en, "R9 reset no write", int'(buf_wr_en), 0);
        check(fixed_cnt == 3'd0 && !fail, "R6 reset result", int'(fixed_cnt), 0);
        for (int n = 0; n < NVEC; n++) run_vec(n);
        // R10: go while busy is ignored
        @(negedge clk);
        init_req = 1'b1;
        stored_ecc = VEC[2].ecc; syn_zero_v = 1'b0; quirk_v = 8'd2; busy_v = 8'd3;
        fin_v = 4'd0; cnt_v = 2'd0;
        @(negedge clk);
        init_req = 1'b0; go = 1'b1;
        @(negedge clk);
        @(negedge clk);
        go = 1'b0;
        check(nload == 1, "R10 go ignored while busy", nload, 1);
        repeat (60) @(negedge clk);
        check(nload == 8 && nstart == 1, "R10 single run", nload, 8);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule